// File: doc/BRIEF.md
# Single-Wire Debug Link Error Handler

This block supervises a debug connection that runs over one open-drain, half-duplex wire carrying asynchronous characters. The wire is pulled high. Either end may only pull it low or let it go. The block is given the sampled wire level, the level and busy flag of the local character transmitter, and a bit length in clock cycles from an external baud measurement unit. From these it recognises three faults. A long low period is a line break. A character whose stop bit reads low is a framing fault. If the wire reads low while the local transmitter is releasing it, that is a collision with the remote end.

When it finds any fault, the block aborts the command in progress and resets the baud measurement unit, each through a one-cycle pulse. It then pulls the wire low for four character times. A character time is ten bit periods: one start bit, eight data bits and one stop bit. A break from the remote end also holds the debug logic in reset until the wire is seen high again. The debug control register is not on that reset and keeps its contents. While the local transmitter is sending, a remote break shows up as a collision, because the wired-AND line pulls the transmitted high bits low.

Top module: `dlk_err_handler`

## Requirements
- R1: While reset is asserted and just after it, `line_o` is 1 (released) with no transmission, and `brk_p_o`, `frm_p_o`, `col_p_o`, `abort_o`, `baud_rst_o` and `dbg_rst_o` are all 0.
- R2: When `line_i` reads 0 on 9 × `bit_period_i` consecutive clock edges, `brk_p_o` pulses once. If the wire goes high after one sample fewer, there is no pulse.
- R3: After a falling edge, the receiver samples the wire in the middle of each bit. The bits are numbered 0 (start) to 9 (stop), spaced `bit_period_i` cycles apart, and the first sample comes `bit_period_i/2` + 1 edges after the falling edge. A stop sample of 0 gives one `frm_p_o` pulse. If the start sample reads 1, the start is treated as false and no fault is raised.
- R4: When `tx_active_i`=1, `tx_level_i`=1 and `line_i`=0, `col_p_o` pulses once per such event.
- R5: Each fault gives exactly one `abort_o` pulse and one `baud_rst_o` pulse. Both are one cycle long and fall in the same cycle.
- R6: After a fault, `line_o` is 0 for exactly 40 × `bit_period_i` consecutive cycles. After that it follows the transmit path again.
- R7: While that low period runs, no fault is detected and the low period does not restart, even if the transmitter is active.
- R8: `dbg_rst_o` rises when a break is detected and stays at 1 until `line_i` reads 1. This holds even when the remote end keeps the wire low past the end of the returned break, and in that case no second break pulse is given.
- R9: A remote break that starts while the transmitter is sending a high level is reported as a collision only, with no break pulse.
- R10: With no fault pending, `line_o` equals `tx_level_i` while `tx_active_i`=1. Driving a low bit does not count as a collision.
- R11: Well-formed characters (stop bit 1, fewer than 9 low bit periods in a row) raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_i | input | 1 | Sampled wire level, already synchronised |
| tx_active_i | input | 1 | Local transmitter is sending a character |
| tx_level_i | input | 1 | Level the transmitter wants on the wire (1 = release) |
| bit_period_i | input | BPW | Clock cycles per bit, from the baud measurement unit |
| line_o | output | 1 | Wire drive, 0 = pull low, 1 = release |
| brk_p_o | output | 1 | One-cycle pulse: line break found |
| frm_p_o | output | 1 | One-cycle pulse: framing fault found |
| col_p_o | output | 1 | One-cycle pulse: transmit collision found |
| abort_o | output | 1 | One-cycle pulse: abort the current debug command |
| baud_rst_o | output | 1 | One-cycle pulse: restart baud measurement |
| dbg_rst_o | output | 1 | Holds debug logic (not its control register) in reset during a remote break |

## Verification
The assertions assume that `line_i` is already synchronised to `clk`. They also assume that `bit_period_i` is at least 2 and changes only while the wire is idle high, since the bit and break counters compare against it every cycle. The bench changes every input on the falling clock edge. It models the wire as the AND of the remote drive and `line_o`, and it changes the bit length only between scenarios. Apart from the single long-break test, the remote end always lets go of the wire before the 40-bit echo finishes.

// File: rtl/dlk_pkg.sv
`timescale 1ns/1ps
package dlk_pkg;

  // receiver sequencer states
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } fr_state_e;

  // the three fault pulses, gathered for the echo trigger
  typedef struct packed {
    logic brk;
    logic frm;
    logic col;
  } fault_t;

endpackage

// File: rtl/dlk_break_det.sv
`timescale 1ns/1ps
module dlk_break_det #(
  parameter int BPW      = 8,
  parameter int BRK_BITS = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           line_i,
  input  logic [BPW-1:0] bit_period_i,
  output logic           brk_p_o,
  output logic           hold_o
);

  localparam int           BW     = $clog2(BRK_BITS + 1);
  localparam logic [BW-1:0] LIM    = BW'(BRK_BITS);
  localparam logic [BW-1:0] LIM_M1 = BW'(BRK_BITS - 1);

  logic [BPW-1:0] cyc_q, cyc_d;
  logic [BW-1:0]  bits_q, bits_d;
  logic           hold_q, hold_d;
  logic           pls_q, pls_d;
  logic           bit_end;

  always_comb begin
    cyc_d   = cyc_q;
    bits_d  = bits_q;
    hold_d  = hold_q;
    pls_d   = 1'b0;
    bit_end = (cyc_q == bit_period_i - BPW'(1));
    if (line_i) begin
      // wire seen high: the low run is over and so is any hold
      cyc_d  = '0;
      bits_d = '0;
      hold_d = 1'b0;
    end else if (!en_i) begin
      // our own echo owns the wire; the hold survives
      cyc_d  = '0;
      bits_d = '0;
    end else if (bits_q < LIM) begin
      if (bit_end) begin
        cyc_d  = '0;
        bits_d = bits_q + BW'(1);
        if ((bits_q == LIM_M1) && !hold_q) begin
          pls_d  = 1'b1;
          hold_d = 1'b1;
        end
      end else begin
        cyc_d = cyc_q + BPW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      bits_q <= '0;
      hold_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      bits_q <= bits_d;
      hold_q <= hold_d;
      pls_q  <= pls_d;
    end
  end

  assign brk_p_o = pls_q;
  assign hold_o  = hold_q;

  AST_BRK_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_p_o |-> $past(!line_i)); // R2
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !line_i) |=> hold_q); // R8

endmodule

// File: rtl/dlk_framer.sv
`timescale 1ns/1ps
module dlk_framer
  import dlk_pkg::*;
#(
  parameter int BPW       = 8,
  parameter int CHAR_BITS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           line_i,
  input  logic [BPW-1:0] bit_period_i,
  output logic           frm_p_o
);

  localparam int            IW   = $clog2(CHAR_BITS);
  localparam logic [IW-1:0] LAST = IW'(CHAR_BITS - 1);

  fr_state_e      st_q, st_d;
  logic [BPW-1:0] cnt_q, cnt_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic           line_q;
  logic           pls_q, pls_d;
  logic [BPW-1:0] half_bp;

  assign half_bp = bit_period_i >> 1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    pls_d = 1'b0;
    unique case (st_q)
      FR_IDLE: begin
        if (en_i && line_q && !line_i) begin
          st_d  = FR_RUN;
          cnt_d = half_bp;
          idx_d = '0;
        end
      end
      FR_RUN: begin
        if (!en_i) begin
          st_d = FR_IDLE;
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - BPW'(1);
        end else begin
          cnt_d = bit_period_i - BPW'(1);
          if ((idx_q == '0) && line_i) begin
            st_d = FR_IDLE;            // glitch, not a start bit
          end else if (idx_q == LAST) begin
            st_d  = FR_IDLE;
            pls_d = !line_i;           // stop bit must read high
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      line_q <= 1'b1;
      pls_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      line_q <= line_i;
      pls_q  <= pls_d;
    end
  end

  assign frm_p_o = pls_q;

  AST_FRM_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frm_p_o |-> $past(!line_i)); // R3

endmodule

// File: rtl/dlk_collide.sv
`timescale 1ns/1ps
module dlk_collide (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tx_active_i,
  input  logic tx_level_i,
  input  logic line_i,
  output logic col_p_o
);

  logic clash, clash_q;
  logic pls_q, pls_d;

  // we release the wire yet it reads low: someone else pulls it
  assign clash = en_i && tx_active_i && tx_level_i && !line_i;

  always_comb begin
    pls_d = clash && !clash_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clash_q <= 1'b0;
      pls_q   <= 1'b0;
    end else begin
      clash_q <= clash;
      pls_q   <= pls_d;
    end
  end

  assign col_p_o = pls_q;

  AST_COL_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    col_p_o |-> $past(tx_active_i && tx_level_i && !line_i)); // R4

endmodule

// File: rtl/dlk_echo.sv
`timescale 1ns/1ps
module dlk_echo #(
  parameter int BPW        = 8,
  parameter int CHAR_BITS  = 10,
  parameter int ECHO_CHARS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fault_i,
  input  logic [BPW-1:0] bit_period_i,
  output logic           busy_o,
  output logic           start_p_o
);

  localparam int            ECHO_BITS = CHAR_BITS * ECHO_CHARS;
  localparam int            EW        = $clog2(ECHO_BITS);
  localparam logic [EW-1:0] LAST      = EW'(ECHO_BITS - 1);

  logic           busy_q, busy_d;
  logic [BPW-1:0] cyc_q, cyc_d;
  logic [EW-1:0]  bit_q, bit_d;
  logic           start_q, start_d;

  always_comb begin
    busy_d  = busy_q;
    cyc_d   = cyc_q;
    bit_d   = bit_q;
    start_d = 1'b0;
    if (!busy_q) begin
      if (fault_i) begin
        busy_d  = 1'b1;
        cyc_d   = '0;
        bit_d   = '0;
        start_d = 1'b1;
      end
    end else if (cyc_q == bit_period_i - BPW'(1)) begin
      cyc_d = '0;
      if (bit_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + EW'(1);
      end
    end else begin
      cyc_d = cyc_q + BPW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cyc_q   <= '0;
      bit_q   <= '0;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cyc_q   <= cyc_d;
      bit_q   <= bit_d;
      start_q <= start_d;
    end
  end

  assign busy_o    = busy_q;
  assign start_p_o = start_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_q) |=> !start_q); // R7

endmodule

// File: rtl/dlk_err_handler.sv
`timescale 1ns/1ps
module dlk_err_handler
  import dlk_pkg::*;
#(
  parameter int BPW        = 8,
  parameter int CHAR_BITS  = 10,
  parameter int ECHO_CHARS = 4,
  parameter int BRK_BITS   = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_i,
  input  logic           tx_active_i,
  input  logic           tx_level_i,
  input  logic [BPW-1:0] bit_period_i,
  output logic           line_o,
  output logic           brk_p_o,
  output logic           frm_p_o,
  output logic           col_p_o,
  output logic           abort_o,
  output logic           baud_rst_o,
  output logic           dbg_rst_o
);

  // reset: asserted at once, removed on a clock edge
  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  fault_t faults;
  logic   echo_busy, echo_start, brk_hold;
  logic   det_en, rx_en, any_fault;

  assign det_en    = !echo_busy;
  assign rx_en     = !echo_busy && !brk_hold;
  assign any_fault = faults.brk | faults.frm | faults.col;

  dlk_break_det #(
    .BPW      (BPW),
    .BRK_BITS (BRK_BITS)
  ) u_brk (
    .clk          (clk),
    .rst_n        (rst_s),
    .en_i         (det_en),
    .line_i       (line_i),
    .bit_period_i (bit_period_i),
    .brk_p_o      (faults.brk),
    .hold_o       (brk_hold)
  );

  dlk_framer #(
    .BPW       (BPW),
    .CHAR_BITS (CHAR_BITS)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_s),
    .en_i         (rx_en),
    .line_i       (line_i),
    .bit_period_i (bit_period_i),
    .frm_p_o      (faults.frm)
  );

  dlk_collide u_col (
    .clk         (clk),
    .rst_n       (rst_s),
    .en_i        (det_en),
    .tx_active_i (tx_active_i),
    .tx_level_i  (tx_level_i),
    .line_i      (line_i),
    .col_p_o     (faults.col)
  );

  dlk_echo #(
    .BPW        (BPW),
    .CHAR_BITS  (CHAR_BITS),
    .ECHO_CHARS (ECHO_CHARS)
  ) u_echo (
    .clk          (clk),
    .rst_n        (rst_s),
    .fault_i      (any_fault),
    .bit_period_i (bit_period_i),
    .busy_o       (echo_busy),
    .start_p_o    (echo_start)
  );

  // open-drain drive: echo pulls low, else the transmitter, else release
  always_comb begin
    if (echo_busy) begin
      line_o = 1'b0;
    end else if (tx_active_i) begin
      line_o = tx_level_i;
    end else begin
      line_o = 1'b1;
    end
  end

  assign brk_p_o    = faults.brk;
  assign frm_p_o    = faults.frm;
  assign col_p_o    = faults.col;
  assign abort_o    = echo_start;
  assign baud_rst_o = echo_start;
  assign dbg_rst_o  = brk_hold;

  AST_ECHO_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(echo_busy) |-> $past(any_fault)); // R6
  AST_QUIET_DURING_ECHO: assert property (@(posedge clk) disable iff (!rst_s)
    (echo_busy && $past(echo_busy)) |-> !(faults.frm || faults.col)); // R7

endmodule

// File: tb/dlk_err_handler_bench.sv
`timescale 1ns/1ps
module dlk_err_handler_bench;

  localparam int BPW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           host = 1'b1;
  logic           tx_active = 1'b0;
  logic           tx_level = 1'b1;
  logic [BPW-1:0] bit_period = 8'd8;
  int             bpv = 8;
  logic           line;
  logic           line_o, brk_p, frm_p, col_p, abort_p, baud_p, dbg_rst;

  assign line = host & line_o;

  always #5 clk = ~clk;

  dlk_err_handler u_dlk_err_handler (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line),
    .tx_active_i  (tx_active),
    .tx_level_i   (tx_level),
    .bit_period_i (bit_period),
    .line_o       (line_o),
    .brk_p_o      (brk_p),
    .frm_p_o      (frm_p),
    .col_p_o      (col_p),
    .abort_o      (abort_p),
    .baud_rst_o   (baud_p),
    .dbg_rst_o    (dbg_rst)
  );

  // event counters sampled on the falling edge
  int n_brk, n_frm, n_col, n_abort, n_baud, n_dbg, n_runs, run, last_run, n_split;
  logic dbg_prev = 1'b0;

  always @(negedge clk) begin
    if (brk_p)   n_brk++;
    if (frm_p)   n_frm++;
    if (col_p)   n_col++;
    if (abort_p) n_abort++;
    if (baud_p)  n_baud++;
    if (abort_p != baud_p) n_split++;
    if (dbg_rst && !dbg_prev) n_dbg++;
    dbg_prev = dbg_rst;
    if (!line_o) run++;
    else if (run != 0) begin
      last_run = run;
      n_runs++;
      run = 0;
    end
  end

  int n_chk, n_fail;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_char(input int data, input int stop);
    for (int b = 0; b < 10; b++) begin
      if (b == 0) host = 1'b0;
      else if (b == 9) host = stop[0];
      else host = data[b-1];
      repeat (bpv) @(negedge clk);
    end
    host = 1'b1;
  endtask

  task automatic hold_low(input int n);
    host = 1'b0;
    repeat (n) @(negedge clk);
    host = 1'b1;
  endtask

  task automatic collide(input int n);
    tx_active = 1'b1;
    tx_level  = 1'b1;
    repeat (3) @(negedge clk);
    host = 1'b0;
    repeat (n) @(negedge clk);
    host = 1'b1;
    tx_active = 1'b0;
  endtask

  task automatic settle();
    repeat (45 * bpv + 40) @(negedge clk);
    while (!line) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
  endtask

  // kind(0 char,1 remote low,2 collide), arg, stop, exp brk, frm, col, echo, dbg rise
  localparam int NV = 10;
  localparam int VEC [NV][8] = '{
    '{0, 'h55, 1, 0, 0, 0, 0, 0},
    '{0, 'hA3, 1, 0, 0, 0, 0, 0},
    '{0, 'hFF, 0, 0, 1, 0, 1, 0},
    '{0, 'h00, 1, 1, 0, 0, 1, 1},
    '{1,   71, 0, 0, 0, 0, 0, 0},
    '{1,   72, 0, 1, 0, 0, 1, 1},
    '{1,  200, 0, 1, 0, 0, 1, 1},
    '{1,    2, 0, 0, 0, 0, 0, 0},
    '{2,    3, 0, 0, 0, 1, 1, 0},
    '{2,  160, 0, 0, 0, 1, 1, 0}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int b0, f0, c0, a0, u0, d0, r0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "line_o in reset", int'(line_o), 1);
    chk("R1", "pulses in reset", int'({brk_p, frm_p, col_p, abort_p, baud_p}), 0);
    chk("R1", "dbg_rst in reset", int'(dbg_rst), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk("R1", "line_o after reset", int'(line_o), 1);
    chk("R1", "dbg_rst after reset", int'(dbg_rst), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      b0 = n_brk; f0 = n_frm; c0 = n_col; a0 = n_abort; u0 = n_baud; d0 = n_dbg; r0 = n_runs;
      case (VEC[i][0])
        0: send_char(VEC[i][1], VEC[i][2]);
        1: hold_low(VEC[i][1]);
        default: collide(VEC[i][1]);
      endcase
      settle();
      chk("R2", $sformatf("vec %0d brk", i), n_brk - b0, VEC[i][3]);
      chk("R3", $sformatf("vec %0d frm", i), n_frm - f0, VEC[i][4]);
      chk(VEC[i][0] == 2 && VEC[i][1] > 100 ? "R9" : "R4",
          $sformatf("vec %0d col", i), n_col - c0, VEC[i][5]);
      chk("R5", $sformatf("vec %0d abort", i), n_abort - a0, VEC[i][6]);
      chk("R5", $sformatf("vec %0d baud_rst", i), n_baud - u0, VEC[i][6]);
      chk("R6", $sformatf("vec %0d echo count", i), n_runs - r0, VEC[i][6]);
      if (VEC[i][6] != 0)
        chk("R6", $sformatf("vec %0d echo length", i), last_run, 40 * bpv);
      chk("R8", $sformatf("vec %0d dbg rises", i), n_dbg - d0, VEC[i][7]);
      chk("R11", $sformatf("vec %0d released after", i), int'(line_o), 1);
    end
    chk("R5", "abort and baud_rst split", n_split, 0);

    // R10 transmit path passes through, low bit is not a collision
    c0 = n_col;
    tx_active = 1'b1; tx_level = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R10", "line_o follows low bit", int'(line_o), 0);
    tx_level = 1'b1;
    repeat (3) @(negedge clk); #1;
    chk("R10", "line_o follows high bit", int'(line_o), 1);
    tx_active = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R10", "no collision on own low bit", n_col - c0, 0);

    // R7 transmitter active during echo raises nothing, echo not restarted
    c0 = n_col; r0 = n_runs; a0 = n_abort;
    send_char('hFF, 0);
    tx_active = 1'b1; tx_level = 1'b1;
    repeat (50) @(negedge clk);
    tx_active = 1'b0;
    settle();
    chk("R7", "collision during echo", n_col - c0, 0);
    chk("R7", "echo count", n_runs - r0, 1);
    chk("R7", "echo length", last_run, 40 * bpv);
    chk("R7", "abort count", n_abort - a0, 1);

    // R8 remote break outlasting the echo
    b0 = n_brk; r0 = n_runs;
    host = 1'b0;
    repeat (500) @(negedge clk); #1;
    chk("R8", "dbg_rst held past echo", int'(dbg_rst), 1);
    chk("R8", "line released after echo", int'(line_o), 1);
    chk("R8", "echo done once", n_runs - r0, 1);
    repeat (100) @(negedge clk);
    host = 1'b1;
    repeat (5) @(negedge clk); #1;
    chk("R8", "dbg_rst clears on high", int'(dbg_rst), 0);
    chk("R8", "single break pulse", n_brk - b0, 1);
    settle();

    // R2 boundary with an odd bit length
    bit_period = 8'd5; bpv = 5;
    repeat (4) @(negedge clk);
    b0 = n_brk;
    hold_low(44);
    settle();
    chk("R2", "bp5 44 low samples", n_brk - b0, 0);
    hold_low(45);
    settle();
    chk("R2", "bp5 45 low samples", n_brk - b0, 1);
    chk("R6", "bp5 echo length", last_run, 200);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule